// File: doc/BRIEF.md
# Fast-to-Slow Bus Bridge with Stall

This block connects a fast 8-bit processor to a slow legacy system bus whose timing comes from a two-phase system clock. Every processor access is decoded. Most accesses go to local fast memory, and they finish in the same cycle. The lower half of the address space selects local RAM and the upper half selects local ROM. Accesses that fall into the two exception windows take a different path. The bridge latches them in registers and holds the processor through its ready line. It then replays the access on the slow bus in step with that bus's phases. For a read, the slow-bus data is handed back when the ready line rises again.

The processor side is a valid/ready handshake. An access completes on a clock where `cpu_valid` and `cpu_rdy` are both high. While `cpu_rdy` is low, the processor must hold its address, write data and direction stable. `cpu_rdy` drops only when an exception-window access is presented, so local accesses never see back-pressure. The slow phase clock comes in asynchronously. Inside the bridge it is synchronised with a chain of flops, and its edges are found after synchronisation. While the slow bus is not carrying a replayed access, it shows a fixed dummy read. The dummy address is a parameter and can be all ones or all zeros.

Top module: `fsb_bridge`

## Requirements
- R1: An access is an exception-window access when address bits [14:12] equal 3'b001, whatever the value of bit 15 (so 16'h1000-16'h1FFF and 16'h9000-16'h9FFF). Such an access asserts neither local select, and `cpu_rdy` stays low until the slow transfer is finished.
- R2: Every other valid access completes in the same cycle with `cpu_rdy` high. It asserts `ram_sel` when bit 15 is 0 and `rom_sel` when bit 15 is 1.
- R3: A write is signalled by `cpu_rw`=0 (1 means read). `mem_we` is asserted only for a valid local RAM write. Writes to the ROM half leave `mem_we` low.
- R4: Whenever no replayed access is on the slow bus, `slow_addr` shows the dummy address (16'hFFFF by default) and `slow_rw`=1.
- R5: An exception request is latched only while the synchronised phase clock is low. If it arrives while the phase clock is high, it waits for the next low half-phase, which lengthens the stall.
- R6: The latched address, write data and direction appear on the slow bus from the next rising edge of the phase clock until its falling edge, and they stay stable for that whole time. `slow_rw`=0 is shown only during a high half-phase.
- R7: For a read, the slow-bus data sampled at the falling edge is shown on `cpu_rdata` when `cpu_rdy` returns high.
- R8: Measured from the moment the request is latched, the stall lasts at least one high half-phase and at most one full slow cycle, plus the synchroniser latency.
- R9: When the transfer finishes, the slow bus goes back to the dummy read and `cpu_rdy` goes high for one completion cycle. The next access then starts from idle.
- R10: While reset is held and right after it, `cpu_rdy`=1, no request is pending, and the slow bus shows the dummy read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access strobe |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdy | output | 1 | Ready; low stalls the processor |
| cpu_rdata | output | 8 | Data returned from a slow-bus read |
| ram_sel | output | 1 | Local RAM select |
| rom_sel | output | 1 | Local ROM select |
| mem_we | output | 1 | Local RAM write enable |
| phi_in | input | 1 | Slow-bus phase clock, asynchronous |
| slow_rdata | input | 8 | Slow-bus read data |
| slow_addr | output | 16 | Slow-bus address |
| slow_wdata | output | 8 | Slow-bus write data |
| slow_rw | output | 1 | Slow-bus direction, 1 = read |

## Verification
Some properties are checked on every cycle by assertions. Exception-window accesses never select local memory, and local accesses never stall. ROM writes never raise `mem_we`. A request is latched only after a low synchronised phase. The driven slow-bus values stay stable, and writes appear only after a high phase. The bus shows the dummy read whenever no transfer is being replayed.

Other behaviour can only be shown by the bench's scenarios. These are the stall lengths for requests that arrive in the low phase and in the high phase, the read data that comes back, and the write address, data and duration seen on the slow bus. They also include the ignoring of bit 15 in the window decode and recovery between back-to-back transfers.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITLOW,
    ST_ARMED,
    ST_DRIVE,
    ST_DONE
  } xfer_st_e;
endpackage

// File: rtl/fsb_phase_sync.sv
module fsb_phase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_async,
  output logic phi_s,
  output logic phi_rise,
  output logic phi_fall
);
  logic [STAGES-1:0] chain;
  logic              phi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain    <= '0;
      phi_prev <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], phi_async};
      phi_prev <= chain[STAGES-1];
    end
  end

  assign phi_s    = chain[STAGES-1];
  assign phi_rise = chain[STAGES-1] & ~phi_prev;
  assign phi_fall = ~chain[STAGES-1] & phi_prev;
endmodule

// File: rtl/fsb_decode.sv
module fsb_decode (
  input  logic       valid,
  input  logic       rw,
  input  logic [3:0] addr_hi,
  output logic       is_exc,
  output logic       ram_sel,
  output logic       rom_sel,
  output logic       mem_we
);
  logic local_hit;

  always_comb begin
    is_exc    = (addr_hi[2:0] == 3'b001);
    local_hit = valid && !is_exc;
    ram_sel   = local_hit && !addr_hi[3];
    rom_sel   = local_hit && addr_hi[3];
    mem_we    = ram_sel && !rw;
  end
endmodule

// File: rtl/fsb_xfer_ctrl.sv
module fsb_xfer_ctrl
  import fsb_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter logic [AW-1:0] DUMMY_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          is_exc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rw,
  input  logic          phi_s,
  input  logic          phi_rise,
  input  logic          phi_fall,
  input  logic [DW-1:0] slow_rdata,
  output logic          rdy,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] slow_addr,
  output logic [DW-1:0] slow_wdata,
  output logic          slow_rw,
  output xfer_st_e      state_o
);
  xfer_st_e      state, state_nx;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          lat_rw;
  logic          do_latch;

  always_comb begin
    state_nx = state;
    do_latch = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (valid && is_exc) begin
          if (phi_s) state_nx = ST_WAITLOW;
          else begin
            state_nx = ST_ARMED;
            do_latch = 1'b1;
          end
        end
      end
      ST_WAITLOW: begin
        if (!phi_s) begin
          state_nx = ST_ARMED;
          do_latch = 1'b1;
        end
      end
      ST_ARMED: if (phi_rise) state_nx = ST_DRIVE;
      ST_DRIVE: if (phi_fall) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_addr  <= DUMMY_ADDR;
      lat_wdata <= '0;
      lat_rw    <= 1'b1;
      rdata     <= '0;
    end else begin
      state <= state_nx;
      if (do_latch) begin
        lat_addr  <= addr;
        lat_wdata <= wdata;
        lat_rw    <= rw;
      end
      if (state == ST_DRIVE && phi_fall && lat_rw) rdata <= slow_rdata;
    end
  end

  always_comb begin
    if (state == ST_DRIVE) begin
      slow_addr  = lat_addr;
      slow_wdata = lat_rw ? '0 : lat_wdata;
      slow_rw    = lat_rw;
    end else begin
      slow_addr  = DUMMY_ADDR;
      slow_wdata = '0;
      slow_rw    = 1'b1;
    end
  end

  assign rdy     = !(valid && is_exc) || (state == ST_DONE);
  assign state_o = state;
endmodule

// File: rtl/fsb_bridge.sv
module fsb_bridge
  import fsb_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit DUMMY_ONES  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_rdy,
  output logic [DW-1:0] cpu_rdata,
  output logic          ram_sel,
  output logic          rom_sel,
  output logic          mem_we,
  input  logic          phi_in,
  input  logic [DW-1:0] slow_rdata,
  output logic [AW-1:0] slow_addr,
  output logic [DW-1:0] slow_wdata,
  output logic          slow_rw
);
  localparam logic [AW-1:0] DUMMY_ADDR = DUMMY_ONES ? {AW{1'b1}} : {AW{1'b0}};

  logic     phi_s, phi_rise, phi_fall;
  logic     is_exc;
  xfer_st_e xfer_state;

  fsb_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi_async(phi_in),
    .phi_s    (phi_s),
    .phi_rise (phi_rise),
    .phi_fall (phi_fall)
  );

  fsb_decode u_dec (
    .valid  (cpu_valid),
    .rw     (cpu_rw),
    .addr_hi(cpu_addr[AW-1:AW-4]),
    .is_exc (is_exc),
    .ram_sel(ram_sel),
    .rom_sel(rom_sel),
    .mem_we (mem_we)
  );

  fsb_xfer_ctrl #(.AW(AW), .DW(DW), .DUMMY_ADDR(DUMMY_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (cpu_valid),
    .is_exc    (is_exc),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .rw        (cpu_rw),
    .phi_s     (phi_s),
    .phi_rise  (phi_rise),
    .phi_fall  (phi_fall),
    .slow_rdata(slow_rdata),
    .rdy       (cpu_rdy),
    .rdata     (cpu_rdata),
    .slow_addr (slow_addr),
    .slow_wdata(slow_wdata),
    .slow_rw   (slow_rw),
    .state_o   (xfer_state)
  );
endmodule

// File: rtl/fsb_bridge_chk.sv
module fsb_bridge_chk
  import fsb_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter logic [AW-1:0] DUMMY_ADDR = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rdy,
  input logic          ram_sel,
  input logic          rom_sel,
  input logic          mem_we,
  input logic          phi_s,
  input xfer_st_e      xfer_state,
  input logic [AW-1:0] slow_addr,
  input logic [DW-1:0] slow_wdata,
  input logic          slow_rw
);
  logic win_hit;
  assign win_hit = (cpu_addr[AW-2:AW-4] == 3'b001);

  a_r1_window_no_local: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && win_hit) |-> (!ram_sel && !rom_sel));

  a_r2_local_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !win_hit) |-> cpu_rdy);

  a_r3_rom_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ram_sel && !cpu_addr[AW-1]));

  a_r4_dummy_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_state inside {ST_IDLE, ST_WAITLOW, ST_ARMED})
      |-> (slow_addr == DUMMY_ADDR && slow_rw && slow_wdata == '0));

  a_r5_latch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_state == ST_ARMED && $past(xfer_state) != ST_ARMED) |-> !$past(phi_s));

  a_r6_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_state == ST_DRIVE && $past(xfer_state) == ST_DRIVE)
      |-> ($stable(slow_addr) && $stable(slow_wdata) && $stable(slow_rw)));

  a_r6_write_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_rw |-> $past(phi_s));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_state == ST_DONE) |-> (cpu_rdy && slow_rw && slow_addr == DUMMY_ADDR));
endmodule

bind fsb_bridge fsb_bridge_chk #(.AW(AW), .DW(DW), .DUMMY_ADDR(DUMMY_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_addr  (cpu_addr),
  .cpu_rdy   (cpu_rdy),
  .ram_sel   (ram_sel),
  .rom_sel   (rom_sel),
  .mem_we    (mem_we),
  .phi_s     (phi_s),
  .xfer_state(xfer_state),
  .slow_addr (slow_addr),
  .slow_wdata(slow_wdata),
  .slow_rw   (slow_rw)
);

// File: tb/fsb_bridge_bench.sv
module fsb_bridge_bench;
  localparam int CLK_P    = 10;
  localparam int PHI_HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rdy, ram_sel, rom_sel, mem_we, slow_rw;
  logic [7:0]  cpu_rdata, slow_rdata, slow_wdata;
  logic [15:0] slow_addr;
  logic        phi_in = 1'b0;

  int tests = 0, fails = 0;
  int phi_cnt = 0;
  bit busy = 1'b0;
  int wr_cnt = 0;
  logic [15:0] seen_addr;
  logic [7:0]  seen_wdata;

  fsb_bridge u_fsb_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .mem_we(mem_we), .phi_in(phi_in),
    .slow_rdata(slow_rdata), .slow_addr(slow_addr), .slow_wdata(slow_wdata),
    .slow_rw(slow_rw)
  );

  always #(CLK_P/2) clk = ~clk;

  // slow-bus responder: data derived from the address
  assign slow_rdata = slow_addr[7:0] ^ 8'h5A;

  always @(negedge clk) begin
    phi_cnt = phi_cnt + 1;
    if (phi_cnt == PHI_HALF) begin
      phi_cnt = 0;
      phi_in  = ~phi_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle reference model
  always @(negedge clk) begin
    if (rst_n) begin
      bit exc, exp_ram, exp_rom, exp_we;
      exc     = (cpu_addr[14:12] == 3'b001);
      exp_ram = cpu_valid && !exc && !cpu_addr[15];
      exp_rom = cpu_valid && !exc && cpu_addr[15];
      exp_we  = exp_ram && !cpu_rw;
      chk({ram_sel, rom_sel} == {exp_ram, exp_rom}, "R1/R2 selects",
          {ram_sel, rom_sel}, {exp_ram, exp_rom});
      chk(mem_we == exp_we, "R3 mem_we", mem_we, exp_we);
      if (!(cpu_valid && exc)) chk(cpu_rdy, "R2 rdy for local", cpu_rdy, 1);
      if (!busy) chk(slow_addr == 16'hFFFF && slow_rw, "R4 dummy read",
                     {slow_addr, 7'd0, slow_rw}, {16'hFFFF, 8'd1});
      if (slow_addr != 16'hFFFF) seen_addr = slow_addr;
      if (!slow_rw) begin
        wr_cnt++;
        seen_wdata = slow_wdata;
      end
    end
  end

  task automatic wait_phase(input logic lvl, input int extra);
    do @(negedge clk); while (phi_in != lvl || phi_cnt != 0);
    repeat (extra - 1) @(negedge clk);
  endtask

  task automatic local_acc(input logic [15:0] a, input logic rw);
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_addr = a; cpu_rw = rw; cpu_wdata = 8'hA5;
    @(negedge clk);
    chk(cpu_rdy, "R2 local completes", cpu_rdy, 1);
    @(posedge clk); #1;
    cpu_valid = 1'b0;
  endtask

  task automatic exc_acc(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                         output logic [7:0] rd, output int stall);
    int guard;
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_addr = a; cpu_rw = rw; cpu_wdata = wd;
    busy = 1'b1; stall = 0; wr_cnt = 0; seen_addr = 16'hFFFF; guard = 0;
    forever begin
      @(negedge clk);
      if (cpu_rdy) break;
      stall++;
      guard++;
      if (guard > 1000) break;
    end
    chk(guard <= 1000, "R9 rdy returns", guard, 0);
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 1'b0; busy = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int st;
    repeat (3) @(negedge clk);
    chk(cpu_rdy && slow_addr == 16'hFFFF && slow_rw, "R10 reset state",
        {cpu_rdy, slow_addr, slow_rw}, {1'b1, 16'hFFFF, 1'b1});
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rdy && slow_addr == 16'hFFFF, "R10 after reset", cpu_rdy, 1);

    local_acc(16'h0234, 1'b1);
    local_acc(16'h7000, 1'b0);
    local_acc(16'hC000, 1'b1);
    local_acc(16'hC000, 1'b0);   // R3 ROM write: mem_we checked low each cycle
    local_acc(16'h3000, 1'b0);   // R1 bit 13 set: not a window
    local_acc(16'hB000, 1'b1);

    // R5/R8: request in low phase
    wait_phase(1'b0, 3);
    exc_acc(16'h1234, 1'b1, 8'h00, rd, st);
    chk(st >= PHI_HALF && st <= 2*PHI_HALF + 1, "R8 stall low", st, 2*PHI_HALF);
    chk(rd == (8'h34 ^ 8'h5A), "R7 read data", rd, 8'h34 ^ 8'h5A);
    chk(seen_addr == 16'h1234, "R6 slow addr", seen_addr, 16'h1234);

    // R5: request in high phase waits for the next low
    wait_phase(1'b1, 3);
    exc_acc(16'h9FFF, 1'b1, 8'h00, rd, st);
    chk(st > 2*PHI_HALF && st <= 3*PHI_HALF + 2, "R5 stall high", st, 3*PHI_HALF);
    chk(rd == (8'hFF ^ 8'h5A), "R7 read data A15", rd, 8'hFF ^ 8'h5A);
    chk(seen_addr == 16'h9FFF, "R1 bit15 ignored", seen_addr, 16'h9FFF);

    // R6 write
    wait_phase(1'b0, 2);
    exc_acc(16'h9005, 1'b0, 8'h3C, rd, st);
    chk(seen_addr == 16'h9005, "R6 write addr", seen_addr, 16'h9005);
    chk(seen_wdata == 8'h3C, "R6 write data", seen_wdata, 8'h3C);
    chk(wr_cnt >= PHI_HALF - 1 && wr_cnt <= PHI_HALF + 1, "R6 write duration",
        wr_cnt, PHI_HALF);

    // R9 back to back
    exc_acc(16'h1FFF, 1'b1, 8'h00, rd, st);
    chk(rd == (8'hFF ^ 8'h5A), "R9 first of pair", rd, 8'hFF ^ 8'h5A);
    exc_acc(16'h1001, 1'b1, 8'h00, rd, st);
    chk(rd == (8'h01 ^ 8'h5A), "R9 second of pair", rd, 8'h01 ^ 8'h5A);
    chk(st <= 3*PHI_HALF + 2, "R8 stall bound pair", st, 3*PHI_HALF);
    local_acc(16'h4000, 1'b1);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule